// File: doc/BRIEF.md
# Field Write Guard Register Pair

This block holds a 64-bit control register together with a 64-bit guard register. Each guard bit that is set freezes the matching bit of the control register against software writes, while clear guard bits let writes through. Software programs the control value first, then sets the guard bits to pin the fields that must not change.

The guard register locks itself. Once it holds any nonzero value, the middle privilege levels can no longer write it, and the write is refused. The top privilege level may always rewrite the guard, including clearing it. The lowest level can write neither register.

Which guard positions exist is fixed at build time. Fifteen positions can carry a guard bit: [18:10] and [5:0]. A parameter selects which of them are present. All other guard bits always read 0.

The write port is a valid/ready stream that never applies back-pressure. `wr_ready` is held high, and every beat with `wr_valid` high is taken on that clock edge. A beat is either applied or refused. Nothing is queued, and the port cannot stall.

Top module: `fldlock_regpair`

## Requirements
- R1: After reset, the control register, the guard register and `wr_refused` are all 0, and `wr_ready` is 1.
- R2: A guard write stores only the fifteen positions [18:10] and [5:0]. All other guard bits read 0 whatever was written.
- R3: A guard position whose bit is 0 in the `IMPL_MASK` parameter always reads 0 and ignores written data.
- R4: An accepted control write gives new = (old & guard) | (wr_data & ~guard). Bits under a set guard bit keep their value.
- R5: A guard write at privilege 1 or 2 while the stored guard is nonzero is refused. Both registers stay unchanged.
- R6: A guard write at privilege 1 or 2 while the stored guard is zero is accepted.
- R7: A guard write at privilege 3 is always accepted, whatever the stored guard value, and may clear it.
- R8: Any write at privilege 0, to either target, is refused and changes nothing.
- R9: `wr_refused` is high in the cycle after a refused beat and low after an accepted beat or an idle cycle. Each refused beat gives exactly one high cycle.
- R10: The lock test uses the stored guard value. A guard write at privilege 1 or 2 that carries only unstorable bits leaves the guard at zero, so the guard stays unlocked.

Encodings: `wr_tgt` selects the control register when 0 and the guard register when 1. `wr_priv` ranges from 0 (lowest) to 3 (highest).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Always 1; the port never stalls |
| wr_tgt | input | 1 | 0 selects control, 1 selects guard |
| wr_priv | input | 2 | Privilege of the writer, 0 lowest to 3 highest |
| wr_data | input | 64 | Write data |
| ctrl_q | output | 64 | Current control register value |
| mask_q | output | 64 | Current guard register value |
| wr_refused | output | 1 | One-cycle flag for each refused beat |

## Verification
The assertions assume three things about the inputs. Reset is held low for at least one clock. `wr_valid` is low during reset. All inputs are stable and known around each rising edge.

The bench keeps within these assumptions. It holds `wr_valid` low throughout reset and drives every input only on the falling edge. It covers all four privilege levels and both targets, plus data patterns that touch reserved, parameter-removed and live guard positions.

// File: rtl/fldlock_pkg.sv
package fldlock_pkg;

  typedef enum logic [1:0] {
    PRIV_USER   = 2'd0,
    PRIV_KERNEL = 2'd1,
    PRIV_HYP    = 2'd2,
    PRIV_TOP    = 2'd3
  } priv_e;

  typedef enum logic {
    TGT_CTRL = 1'b0,
    TGT_MASK = 1'b1
  } tgt_e;

  // Positions able to carry a guard bit: [18:10] and [5:0]
  localparam logic [63:0] GUARD_POS = 64'h0000_0000_0007_FC3F;

endpackage

// File: rtl/fldlock_gate.sv
module fldlock_gate
  import fldlock_pkg::*;
(
  input  logic  beat,
  input  tgt_e  tgt,
  input  priv_e priv,
  input  logic  guard_set,
  output logic  ctrl_we,
  output logic  mask_we,
  output logic  refuse
);

  logic lvl_ok;
  logic mask_ok;

  always_comb begin
    lvl_ok  = (priv != PRIV_USER);
    mask_ok = (priv == PRIV_TOP) || !guard_set;
    ctrl_we = beat && lvl_ok && (tgt == TGT_CTRL);
    mask_we = beat && lvl_ok && (tgt == TGT_MASK) && mask_ok;
    refuse  = beat && !(ctrl_we || mask_we);
  end

endmodule

// File: rtl/fldlock_maskreg.sv
module fldlock_maskreg #(
  parameter int          DATA_W = 64,
  parameter logic [DATA_W-1:0] LEGAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic              nonzero
);

  logic [DATA_W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  store_q <= '0;
    else if (we) store_q <= wdata & LEGAL;
  end

  assign value   = store_q;
  assign nonzero = |store_q;

endmodule

// File: rtl/fldlock_ctrlreg.sv
module fldlock_ctrlreg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] guard,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                  bit_q <= 1'b0;
      else if (we && !guard[i])    bit_q <= wdata[i];
    end
    assign value[i] = bit_q;
  end

endmodule

// File: rtl/fldlock_regpair.sv
module fldlock_regpair
  import fldlock_pkg::*;
#(
  parameter int                DATA_W    = 64,
  parameter logic [DATA_W-1:0] IMPL_MASK = DATA_W'(64'h0000_0000_0007_FC3F)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_tgt,
  input  logic [1:0]        wr_priv,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              wr_refused
);

  localparam logic [DATA_W-1:0] LEGAL = DATA_W'(GUARD_POS) & IMPL_MASK;

  logic ctrl_we, mask_we, refuse, guard_set;
  logic refused_q;

  assign wr_ready = 1'b1;

  fldlock_gate u_gate (
    .beat      (wr_valid),
    .tgt       (tgt_e'(wr_tgt)),
    .priv      (priv_e'(wr_priv)),
    .guard_set (guard_set),
    .ctrl_we   (ctrl_we),
    .mask_we   (mask_we),
    .refuse    (refuse)
  );

  fldlock_maskreg #(.DATA_W(DATA_W), .LEGAL(LEGAL)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mask_we),
    .wdata   (wr_data),
    .value   (mask_q),
    .nonzero (guard_set)
  );

  fldlock_ctrlreg #(.DATA_W(DATA_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctrl_we),
    .guard (mask_q),
    .wdata (wr_data),
    .value (ctrl_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) refused_q <= 1'b0;
    else        refused_q <= refuse;
  end
  assign wr_refused = refused_q;

  // Checks
  assert_ctrl_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_tgt && wr_priv != 2'd0) |=>
      ((((ctrl_q ^ $past(ctrl_q)) & $past(mask_q)) == '0) &&
       (((ctrl_q ^ $past(wr_data)) & ~$past(mask_q)) == '0)));

  assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_tgt && (wr_priv == 2'd1 || wr_priv == 2'd2) && mask_q != '0) |=>
      (mask_q == $past(mask_q) && wr_refused));

  assert_unlocked_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_tgt && wr_priv != 2'd0 && mask_q == '0) |=>
      (mask_q == ($past(wr_data) & LEGAL) && !wr_refused));

  assert_top_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_tgt && wr_priv == 2'd3) |=>
      (mask_q == ($past(wr_data) & LEGAL)));

  assert_lowest_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_priv == 2'd0) |=>
      (wr_refused && $stable(ctrl_q) && $stable(mask_q)));

  assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_refused |-> $past(wr_valid));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~LEGAL) == '0);

endmodule

// File: tb/test_fldlock_regpair.sv
module test_fldlock_regpair;

  localparam logic [63:0] IMPL  = 64'h0000_0000_0003_FC1F; // bits 18 and 5 removed (R3)
  localparam logic [63:0] LEGAL = 64'h0000_0000_0007_FC3F & IMPL;

  typedef struct {
    logic [63:0] ctrl;
    logic [63:0] mask;
    logic        refused;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic        wr_tgt = 1'b0;
  logic [1:0]  wr_priv = 2'd0;
  logic [63:0] wr_data = '0;
  logic [63:0] ctrl_q, mask_q;
  logic        wr_refused;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_ctrl = '0, m_mask = '0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  fldlock_regpair #(.DATA_W(64), .IMPL_MASK(IMPL)) i_fldlock_regpair (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_tgt(wr_tgt), .wr_priv(wr_priv), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .mask_q(mask_q), .wr_refused(wr_refused)
  );

  task automatic chk64(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Driver: one beat per cycle, model pushes the expected post-edge state
  task automatic step(logic v, logic tgt, logic [1:0] prv, logic [63:0] d, string tag);
    exp_t e;
    logic ok;
    @(negedge clk);
    wr_valid = v; wr_tgt = tgt; wr_priv = prv; wr_data = d;
    ok = 1'b0;
    if (v && prv != 2'd0) begin
      if (!tgt) begin
        m_ctrl = (m_ctrl & m_mask) | (d & ~m_mask);
        ok = 1'b1;
      end else if (prv == 2'd3 || m_mask == '0) begin
        m_mask = d & LEGAL;
        ok = 1'b1;
      end
    end
    e.ctrl = m_ctrl; e.mask = m_mask; e.refused = v && !ok; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk64(e.tag, "ctrl_q", ctrl_q, e.ctrl);
      chk64(e.tag, "mask_q", mask_q, e.mask);
      chk64(e.tag, "wr_refused", {63'd0, wr_refused}, {63'd0, e.refused});
      chk64("R9", "wr_ready", {63'd0, wr_ready}, 64'd1);
    end
  end

  task automatic run_all();
    logic [63:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk64("R1", "ctrl_q", ctrl_q, '0);
    chk64("R1", "mask_q", mask_q, '0);
    chk64("R1", "wr_refused", {63'd0, wr_refused}, '0);
    chk64("R1", "wr_ready", {63'd0, wr_ready}, 64'd1);

    step(1, 0, 2'd2, 64'hAAAA_5555_F0F0_0F0F, "R4");
    step(1, 1, 2'd2, 64'hFFF8_0000_0000_03C0, "R10");   // unstorable only
    step(1, 1, 2'd2, 64'h0000_0000_0004_0020, "R3");    // removed bits only
    step(0, 0, 2'd0, '0, "R9");
    step(1, 1, 2'd1, '1, "R6");                         // lock: mask = LEGAL
    step(0, 0, 2'd0, '0, "R2");
    step(1, 0, 2'd2, 64'h5555_AAAA_0F0F_F0F0, "R4");
    step(1, 1, 2'd2, 64'h0, "R5");
    step(1, 1, 2'd1, 64'h0000_0000_0000_0001, "R5");
    step(0, 0, 2'd0, '0, "R9");
    step(1, 1, 2'd3, 64'h0000_0000_0000_0401, "R7");
    step(1, 0, 2'd3, 64'h0, "R4");
    step(1, 1, 2'd3, 64'h0, "R7");
    step(1, 0, 2'd0, '1, "R8");
    step(1, 1, 2'd0, 64'h1, "R8");
    step(0, 0, 2'd0, '0, "R9");
    step(1, 0, 2'd1, 64'h0123_4567_89AB_CDEF, "R4");

    lf = 64'hACE1_2345_6789_BEEF;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      step(lf[7], lf[3], lf[9:8], lf, "R4");
    end
    step(0, 0, 2'd0, '0, "R9");
    step(0, 0, 2'd0, '0, "R9");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule